// File: doc/BRIEF.md
# Pre-Trigger Sample Capture Controller

This block captures a stream of samples into an internal ring buffer so that the newest words received before an event are kept. An arm strobe clears the buffer and starts recording. While recording, every sample offered on the input stream is accepted and stored. Once the buffer is full, each new sample replaces the oldest stored one, so the buffer always holds the most recent `DEPTH` samples. Losing old data in this way is expected and is not flagged.

A trigger strobe stops recording and raises an interrupt request. The request stays high until the processor pulses an acknowledge input. The processor then drains the buffer through a read stream, oldest word first, until the empty flag is set. A buffer-level output reports how many words are held.

Input stream rule: `smp_ready` is high exactly while recording. A producer that holds `smp_valid` outside recording stalls, and nothing is stored. Output stream rule: `rd_valid` is high only when recording is stopped and the buffer is not empty. `rd_data` shows the oldest word. A word is consumed on a cycle where `rd_valid` and `rd_ready` are both high.

Top module: `pretrig_capture`

## Requirements
- R1: `smp_ready` is 1 exactly while recording. A sample is stored on a clock edge where `smp_valid` and `smp_ready` are both 1, and no sample is stored at any other time.
- R2: A high `arm` while stopped starts recording from the next cycle. At that same edge the buffer is emptied, so `fifo_level` reads 0. The sample presented in the arm cycle is not stored.
- R3: A high `trig` while recording stops recording from the next cycle. A sample accepted in the trigger cycle is stored as the newest word.
- R4: A sample accepted while `fifo_level` equals `DEPTH` drops the oldest stored word and stores the new one. `fifo_level` stays at `DEPTH`.
- R5: Overwriting on a full buffer raises no interrupt and does not stop recording.
- R6: `done_irq` rises in the cycle after a trigger ends recording. It holds until a cycle with `irq_ack` high and is 0 after that edge. A new trigger in the acknowledge cycle keeps it at 1.
- R7: `rd_data` is the oldest stored word whenever `rd_valid` is 1. Each accepted read removes that word, and the words leave in the order they were stored.
- R8: `trig` while stopped is ignored: recording does not start and `done_irq` does not rise.
- R9: `arm` while recording has no effect: the buffer is not emptied and recording continues.
- R10: `fifo_level` equals the number of stored words (0 to `DEPTH`), and `fifo_empty` is 1 exactly when it is 0.
- R11: `rd_valid` is 0 while recording or when the buffer is empty. `rd_ready` without `rd_valid` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted (high while recording) |
| smp_data | input | DATA_W | Sample word |
| arm | input | 1 | Start recording, flushing the buffer |
| trig | input | 1 | Stop recording and raise the interrupt |
| rd_valid | output | 1 | Oldest word available to the processor |
| rd_ready | input | 1 | Processor takes the word |
| rd_data | output | DATA_W | Oldest stored word |
| fifo_empty | output | 1 | Buffer holds no word |
| fifo_level | output | $clog2(DEPTH+1) | Number of stored words |
| done_irq | output | 1 | End-of-record interrupt request |
| irq_ack | input | 1 | Clears `done_irq` |

## Verification
The bench first records more than `DEPTH` samples. A design that grows the level, or that advances only one pointer on a full buffer, would then read back stale or out-of-order words or report a wrong level. The trigger cycle carries a sample; if that word were lost, the drained sequence would be one short at the end. The bench also re-arms while recording, sends triggers while stopped, and issues reads during recording and on an empty buffer. Flushing at the wrong time, raising a false interrupt, or a read pointer that moves without a handshake each shows up as a level, data or interrupt mismatch against the queue model.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
  typedef enum logic {ST_STOPPED = 1'b0, ST_RECORD = 1'b1} rec_state_t;
endpackage

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import pretrig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic trig,
  input  logic irq_ack,
  output logic recording,
  output logic flush,
  output logic irq
);
  rec_state_t state_q;
  logic       irq_q;

  assign recording = (state_q == ST_RECORD);
  assign flush     = (state_q == ST_STOPPED) && arm;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_STOPPED;
    end else begin
      case (state_q)
        ST_STOPPED: if (arm)  state_q <= ST_RECORD;
        ST_RECORD:  if (trig) state_q <= ST_STOPPED;
        default:              state_q <= ST_STOPPED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  irq_q <= 1'b0;
    else if (recording && trig)  irq_q <= 1'b1;
    else if (irq_ack)            irq_q <= 1'b0;
  end

  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!recording && arm) |=> recording);
  a_r3_trig_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (recording && trig) |=> !recording);
  a_r6_irq_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (recording && trig) |=> irq);
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  a_r8_idle_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (!recording && !arm) |=> !recording);
  a_r8_no_false_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!recording && !irq) |=> !irq);
  a_r9_arm_in_record: assert property (@(posedge clk) disable iff (!rst_n)
    (recording && !trig) |=> recording);
endmodule

// File: rtl/pretrig_ring.sv
module pretrig_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign count   = cnt_q;
  assign rd_data = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      wptr_q <= bump(wptr_q);
      if (full) rptr_q <= bump(rptr_q);
      else      cnt_q  <= cnt_q + 1'b1;
    end else if (rd_en) begin
      rptr_q <= bump(rptr_q);
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  a_r4_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && full) |=> (cnt_q == FULL_CNT));
  a_r2_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  a_r7_read_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !flush) |=> $stable(cnt_q));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_en);
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              arm,
  input  logic              trig,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_empty,
  output logic [CNT_W-1:0]  fifo_level,
  output logic              done_irq,
  input  logic              irq_ack
);
  logic recording, flush, wr_en, rd_en;
  logic [CNT_W-1:0] level;

  pretrig_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .trig      (trig),
    .irq_ack   (irq_ack),
    .recording (recording),
    .flush     (flush),
    .irq       (done_irq)
  );

  pretrig_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_data (smp_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .count   (level)
  );

  assign smp_ready  = recording;
  assign wr_en      = recording && smp_valid;
  assign fifo_empty = (level == '0);
  assign fifo_level = level;
  assign rd_valid   = !recording && !fifo_empty;
  assign rd_en      = rd_valid && rd_ready;

  a_r1_store_when_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && (level != '0)) |=> (fifo_level != '0));
  a_r5_overflow_keeps_recording: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !trig && (level == CNT_W'(DEPTH))) |=> (smp_ready && !$rose(done_irq)));
endmodule

// File: tb/pretrig_capture_tb_top.sv
module pretrig_capture_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, arm = 1'b0, trig = 1'b0, rd_ready = 1'b0, irq_ack = 1'b0;
  logic [DATA_W-1:0] smp_data = '0;
  logic smp_ready, rd_valid, fifo_empty, done_irq;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0] fifo_level;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [DATA_W-1:0] q[$];
  bit m_rec = 0;
  bit m_irq = 0;
  logic [DATA_W-1:0] seq_v = 16'h1000;

  always #4 clk = ~clk;

  pretrig_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .arm(arm), .trig(trig), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_level(fifo_level), .done_irq(done_irq), .irq_ack(irq_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // Compare every visible output against the queue model.
  task automatic compare_all();
    check("R1 smp_ready", 32'(smp_ready), 32'(m_rec));
    check("R10 fifo_level", 32'(fifo_level), 32'(q.size()));
    check("R10 fifo_empty", 32'(fifo_empty), 32'(q.size() == 0));
    check("R11 rd_valid", 32'(rd_valid), 32'(!m_rec && q.size() > 0));
    if (!m_rec && q.size() > 0) check("R7 rd_data", 32'(rd_data), 32'(q[0]));
    check("R6 done_irq", 32'(done_irq), 32'(m_irq));
  endtask

  // One clock: drive at negedge, compare, then advance the model at posedge.
  task automatic cyc(input bit v, input bit a, input bit t, input bit r, input bit k);
    bit old_rec, old_irq;
    @(negedge clk);
    smp_valid = v; arm = a; trig = t; rd_ready = r; irq_ack = k;
    if (v) begin seq_v = seq_v + 16'h0011; smp_data = seq_v; end
    #1;
    compare_all();
    @(posedge clk);
    old_rec = m_rec; old_irq = m_irq;
    if (!old_rec && r && q.size() > 0) void'(q.pop_front());
    if (old_rec && v) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back(smp_data);
    end
    if (!old_rec && a) begin m_rec = 1; q.delete(); end
    else if (old_rec && t) m_rec = 0;
    if (old_rec && t) m_irq = 1;
    else if (k) m_irq = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // Reset state
    check("R10 reset level", 32'(fifo_level), 32'd0);
    check("R6 reset irq", 32'(done_irq), 32'd0);
    check("R1 reset ready", 32'(smp_ready), 32'd0);

    // R8: trigger while stopped is ignored
    cyc(1, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R8 no record", 32'(smp_ready), 32'd0);
    check("R8 no irq", 32'(done_irq), 32'd0);

    // R2: arm with a sample present; that sample is not stored
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R2 flushed level", 32'(fifo_level), 32'd0);
    // R1: gaps in valid; R11: read during recording ignored
    cyc(1, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0);
    // R3: sample in trigger cycle is stored
    cyc(1, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R3 last word kept", 32'(fifo_level), 32'd3);
    // R6: irq holds without ack
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // R7: partial drain, then ack
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0);
    check("R6 acked", 32'(done_irq), 32'd0);

    // R2: re-arm flushes remaining word; R4/R5: overflow
    cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < 2 * DEPTH + 3; i++) begin
      cyc(1, (i == 5), 0, 0, 0); // R9: arm during recording has no effect
    end
    check("R4 level at depth", 32'(fifo_level), 32'(DEPTH));
    check("R5 no irq on overflow", 32'(done_irq), 32'd0);
    check("R5 still recording", 32'(smp_ready), 32'd1);
    cyc(1, 0, 1, 0, 0);
    // R7: drain fully; R11: extra reads on empty
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 0, 1, 0);
    check("R7 drained empty", 32'(fifo_empty), 32'd1);

    // R6: trigger in ack cycle keeps irq
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 0);
    check("R6 set wins", 32'(done_irq), 32'd1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule